// File: doc/BRIEF.md
# Multi-Source Up/Down Timer

This block is a 16-bit up/down timer whose behaviour is set by one 8-bit control word. The control word turns counting on and off, picks a count direction, picks where count steps come from and where the direction comes from, and sets a power-of-two divider for the internal time base. Steps can come from the system clock divided by four and then by the divider, or from either edge of an external clock pin. They can also come from a companion timer, either on its overflow or in lockstep with its own steps. One mode reads the two external pins as the A and B phases of a rotary encoder.

Both pins pass through two-flop synchronizers before any edge is detected. The counter wraps in both directions and marks every wrap with a one-cycle strobe, so a second timer can be chained behind this one. Only the control word can be written. The count value and the wrap strobe are the block's outputs.

Top module: `updn_timer`

## Requirements
- R1: After reset the control word reads 0x00, the count is 0 and no wrap strobe is given. Pin activity does not move the count while the control word is 0x00.
- R2: A write stores all eight bits of the control word, and they read back on the next cycle. The bits are: bit 7 enable (1 = run), bit 6 direction (1 = up, 0 = down), bits 5:3 source mode, bits 2:0 divider exponent P.
- R3: In modes 000 and 010 the count steps once every 4*2^P clock cycles. The first step lands exactly 4*2^P cycles after the write edge, because every control write restarts the divider. The count never moves by more than one per cycle.
- R4: While the enable bit is 0 the count holds its value. Re-enabling restarts the divider, so a full period passes before the next step.
- R5: In modes 001, 101 and 011 each rising edge and each falling edge of the external clock pin is one step. The count changes on the third rising system-clock edge after the pin changes.
- R6: Modes 000, 001, 101 and 100 take their direction from bit 6. Modes 010 and 011 take it from the direction pin (1 = up). In mode 011 a change on the direction pin alone is not a step.
- R7: Mode 100 steps once per cycle in which the companion overflow input is high, with bit 6 as the direction. The companion tick input has no effect in this mode.
- R8: Mode 110 steps once per cycle in which the companion tick input is high, counting up when the companion direction input is 1, whatever bit 6 holds. The companion overflow input has no effect in this mode.
- R9: Mode 111 treats the clock pin as phase A and the direction pin as phase B. Each single-phase change is one step. The (A,B) sequence 00, 01, 11, 10, 00 counts up, and the reverse order counts down.
- R10: In mode 111, a cycle in which both synchronized phases change together gives no step.
- R11: Counting up from 0xFFFF gives 0x0000 and counting down from 0x0000 gives 0xFFFF. Each such wrap raises the wrap strobe for exactly one cycle, and the strobe is never raised otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Control-word write strobe |
| regWdata | input | 8 | Control-word write data |
| regRdata | output | 8 | Current control word |
| extClkPin | input | 1 | External clock pin, or encoder phase A (asynchronous) |
| extDirPin | input | 1 | External direction pin, or encoder phase B (asynchronous) |
| compTick | input | 1 | Companion timer step strobe |
| compDir | input | 1 | Companion timer direction (1 = up) |
| compOvf | input | 1 | Companion timer wrap strobe |
| count | output | 16 | Counter value |
| ovfStrobe | output | 1 | One-cycle pulse on every wrap |

## Verification
The bench measures when the first divided step arrives after a write and after re-enabling. A divider that is not restarted would step early, and one that is off by one would step a cycle late. It counts both edges of the external clock and checks the synchronizer latency to the cycle, so a design that counts only rising edges, or that adds or drops a flop stage, is caught. It drives the encoder through a full forward cycle, one reverse step and a simultaneous change of both phases, which exposes a wrong direction formula or a double transition that is counted. It also walks the counter across zero in both directions and counts strobe pulses, so a missed wrap, a stretched strobe, or a companion input that leaks into the wrong mode changes the tallies.

// File: rtl/timer_pkg.sv
package timer_pkg;
  parameter int TMR_PRE_W  = 3;
  parameter int TMR_MODE_W = 3;
  localparam int TMR_CTRL_W = 2 + TMR_MODE_W + TMR_PRE_W;

  typedef struct packed {
    logic                  en;
    logic                  dirUp;
    logic [TMR_MODE_W-1:0] mode;
    logic [TMR_PRE_W-1:0]  pre;
  } ctrl_t;

  // strobes from control to datapath
  typedef struct packed {
    logic step;
    logic up;
  } step_t;
endpackage

// File: rtl/timer_pin_sync.sv
module timer_pin_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] pinIn,
  output logic [W-1:0] pinNow,
  output logic [W-1:0] pinPrev
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[0] <= '0;
        else       stg[0] <= pinIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[s] <= '0;
        else       stg[s] <= stg[s-1];
      end
    end
  end

  assign pinNow = stg[STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= '0;
    else       pinPrev <= pinNow;
  end
endmodule

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int BASE_LOG = 2,
  parameter int PRE_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);
  localparam int DIV_W = BASE_LOG + (1 << PRE_W) - 1;

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] limit;
  int               shAmt;

  always_comb begin
    shAmt = BASE_LOG + int'(pre);
    limit = ~({DIV_W{1'b1}} << shAmt);
  end

  assign tick = run && (divCnt == limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              divCnt <= '0;
    else if (clear || !run) divCnt <= '0;
    else if (tick)          divCnt <= '0;
    else                    divCnt <= divCnt + 1'b1;
  end
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWe,
  input  logic [TMR_CTRL_W-1:0] regWdata,
  input  logic [1:0]            pinNow,
  input  logic [1:0]            pinPrev,
  input  logic                  preTick,
  input  logic                  compTick,
  input  logic                  compDir,
  input  logic                  compOvf,
  output ctrl_t                 ctrlQ,
  output step_t                 stb
);
  logic clkEdge, aChg, bChg, qValid, qUp;
  logic srcStep, srcUp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      ctrlQ <= '0;
    else if (regWe) ctrlQ <= ctrl_t'(regWdata);
  end

  always_comb begin
    clkEdge = pinNow[0] ^ pinPrev[0];
    aChg    = pinNow[0] ^ pinPrev[0];
    bChg    = pinNow[1] ^ pinPrev[1];
    qValid  = aChg ^ bChg;
    qUp     = pinPrev[0] ^ pinNow[1];
  end

  always_comb begin
    srcStep = 1'b0;
    srcUp   = ctrlQ.dirUp;
    unique case (ctrlQ.mode) inside
      3'b000: begin srcStep = preTick;  srcUp = ctrlQ.dirUp; end
      3'b?01: begin srcStep = clkEdge;  srcUp = ctrlQ.dirUp; end
      3'b010: begin srcStep = preTick;  srcUp = pinNow[1];   end
      3'b011: begin srcStep = clkEdge;  srcUp = pinNow[1];   end
      3'b100: begin srcStep = compOvf;  srcUp = ctrlQ.dirUp; end
      3'b110: begin srcStep = compTick; srcUp = compDir;     end
      3'b111: begin srcStep = qValid;   srcUp = qUp;         end
      default: begin srcStep = 1'b0;    srcUp = ctrlQ.dirUp; end
    endcase
    stb.step = ctrlQ.en & srcStep;
    stb.up   = srcUp;
  end
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  step_t            stb,
  output logic [CNT_W-1:0] cntQ,
  output logic             ovfQ
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      ovfQ <= 1'b0;
    end else if (stb.step) begin
      if (stb.up) begin
        cntQ <= cntQ + 1'b1;
        ovfQ <= (cntQ == CNT_MAX);
      end else begin
        cntQ <= cntQ - 1'b1;
        ovfQ <= (cntQ == '0);
      end
    end else begin
      ovfQ <= 1'b0;
    end
  end
endmodule

// File: rtl/updn_timer.sv
module updn_timer
  import timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int BASE_LOG    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWe,
  input  logic [TMR_CTRL_W-1:0] regWdata,
  output logic [TMR_CTRL_W-1:0] regRdata,
  input  logic                  extClkPin,
  input  logic                  extDirPin,
  input  logic                  compTick,
  input  logic                  compDir,
  input  logic                  compOvf,
  output logic [CNT_W-1:0]      count,
  output logic                  ovfStrobe
);
  logic [1:0] pinNow, pinPrev;
  logic       preTick;
  ctrl_t      ctrlQ;
  step_t      stb;

  timer_pin_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .pinIn({extDirPin, extClkPin}),
    .pinNow(pinNow), .pinPrev(pinPrev)
  );

  timer_prescaler #(.BASE_LOG(BASE_LOG), .PRE_W(TMR_PRE_W)) pre_i (
    .clk(clk), .rstN(rstN), .clear(regWe), .run(ctrlQ.en),
    .pre(ctrlQ.pre), .tick(preTick)
  );

  timer_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .pinNow(pinNow), .pinPrev(pinPrev), .preTick(preTick),
    .compTick(compTick), .compDir(compDir), .compOvf(compOvf),
    .ctrlQ(ctrlQ), .stb(stb)
  );

  timer_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .cntQ(count), .ovfQ(ovfStrobe)
  );

  assign regRdata = ctrlQ;
endmodule

// File: rtl/updn_timer_chk.sv
module updn_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int CTRL_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [CTRL_W-1:0] regWdata,
  input logic [CTRL_W-1:0] regRdata,
  input logic              compTick,
  input logic              compOvf,
  input logic [CNT_W-1:0]  count,
  input logic              ovfStrobe
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] ONE  = 1;

  assert_readback_R2: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> regRdata == $past(regWdata));

  assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(count) |-> (count == $past(count) + ONE) || (count == $past(count) - ONE));

  assert_frozen_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regRdata[7]) |-> $stable(count));

  assert_tick_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata[5:3] == 3'b100 && !compOvf) |=> $stable(count));

  assert_ovf_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata[5:3] == 3'b110 && !compTick) |=> $stable(count));

  assert_wrap_only_R11: assert property (@(posedge clk) disable iff (!rstN)
    ovfStrobe |-> ((count == '0 && $past(count) == CMAX) ||
                   (count == CMAX && $past(count) == '0)));
endmodule

bind updn_timer updn_timer_chk #(.CNT_W(CNT_W), .CTRL_W(timer_pkg::TMR_CTRL_W)) chk_i (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
  .regRdata(regRdata), .compTick(compTick), .compOvf(compOvf),
  .count(count), .ovfStrobe(ovfStrobe)
);

// File: tb/updn_timer_tb_top.sv
`timescale 1ns/1ps
module updn_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [7:0]  regWdata = '0;
  logic [7:0]  regRdata;
  logic        extClkPin = 1'b0, extDirPin = 1'b0;
  logic        compTick = 1'b0, compDir = 1'b0, compOvf = 1'b0;
  logic [15:0] count;
  logic        ovfStrobe;

  int total = 0, bad = 0, ovfSeen = 0;
  bit finished = 0;

  typedef struct { int sel; int exp; string tag; } item_t;
  item_t sbq[$];

  always #2 clk = ~clk;

  updn_timer dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .extClkPin(extClkPin), .extDirPin(extDirPin),
    .compTick(compTick), .compDir(compDir), .compOvf(compOvf),
    .count(count), .ovfStrobe(ovfStrobe)
  );

  always @(negedge clk) if (ovfStrobe) ovfSeen++;

  // monitor: pops expected items and compares them with what the ports show
  initial begin
    forever begin
      item_t it;
      int act;
      wait (sbq.size() != 0);
      it = sbq.pop_front();
      case (it.sel)
        0: act = int'(count);
        1: act = int'(regRdata);
        default: act = ovfSeen;
      endcase
      total++;
      if (act != it.exp) begin
        bad++;
        $display("FAIL %s actual=%0h expected=%0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expectCnt(int v, string tag); sbq.push_back('{0, v, tag}); endtask
  task automatic expectReg(int v, string tag); sbq.push_back('{1, v, tag}); endtask
  task automatic expectOvf(int v, string tag); sbq.push_back('{2, v, tag}); endtask
  task automatic waitN(int n); repeat (n) @(negedge clk); endtask
  task automatic wrCtrl(logic [7:0] v);
    regWe = 1'b1; regWdata = v; @(negedge clk); regWe = 1'b0;
  endtask
  task automatic pulseTick(); compTick = 1'b1; @(negedge clk); compTick = 1'b0; endtask
  task automatic pulseOvf();  compOvf  = 1'b1; @(negedge clk); compOvf  = 1'b0; endtask

  task automatic summary();
    wait (sbq.size() == 0);
    #1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    waitN(3); rstN = 1'b1; waitN(1);
    // R1: reset state, pins ignored with control word 0x00
    expectReg(8'h00, "R1 ctrl after reset");
    expectCnt(0, "R1 count after reset");
    for (int i = 0; i < 4; i++) begin extClkPin = ~extClkPin; waitN(5); end
    expectCnt(0, "R1 pins ignored");
    expectOvf(0, "R1 no strobe");

    // R2/R3: internal base, up, P=1 -> 8 cycles
    wrCtrl(8'hC1);
    expectReg(8'hC1, "R2 readback");
    waitN(7); expectCnt(0, "R3 first step not early");
    waitN(1); expectCnt(1, "R3 first step on time");
    waitN(16); expectCnt(3, "R3 period");
    // R4: disable freezes, re-enable restarts divider
    wrCtrl(8'h41); waitN(40);
    expectCnt(3, "R4 frozen");
    expectReg(8'h41, "R2 readback disabled");
    wrCtrl(8'hC1);
    waitN(7); expectCnt(3, "R4 restart full period");
    waitN(1); expectCnt(4, "R4 step after restart");
    wrCtrl(8'h00);
    // R6: internal base, down via bit 6, P=0 -> 4 cycles
    wrCtrl(8'h80);
    waitN(3); expectCnt(4, "R3 P0 not early");
    waitN(1); expectCnt(3, "R6 bit6 down");
    wrCtrl(8'h00);
    // R6: mode 010 direction from pin, bit 6 ignored
    wrCtrl(8'hD0); waitN(4); expectCnt(2, "R6 pin low counts down");
    wrCtrl(8'h00);
    extDirPin = 1'b1; waitN(5);
    wrCtrl(8'hD0); waitN(4); expectCnt(3, "R6 pin high counts up");
    wrCtrl(8'h00);

    // R5: external clock both edges, latency 3 edges
    wrCtrl(8'hC8);
    extClkPin = 1'b1; waitN(2); expectCnt(3, "R5 latency not early");
    waitN(1); expectCnt(4, "R5 rising edge");
    extClkPin = 1'b0; waitN(5); expectCnt(5, "R5 falling edge");
    extClkPin = 1'b1; waitN(5); expectCnt(6, "R5 rising again");
    wrCtrl(8'hA8);
    extClkPin = 1'b0; waitN(5);
    extClkPin = 1'b1; waitN(5); expectCnt(4, "R5 mode 101 down");
    wrCtrl(8'h98);
    extClkPin = 1'b0; waitN(5); expectCnt(5, "R6 mode 011 pin up");
    extDirPin = 1'b0; waitN(5); expectCnt(5, "R6 dir pin alone no step");
    extClkPin = 1'b1; waitN(5); expectCnt(4, "R6 mode 011 pin down");
    wrCtrl(8'h00);

    // R7: companion overflow as clock
    wrCtrl(8'hE0);
    pulseTick(); pulseTick(); waitN(1); expectCnt(4, "R7 tick ignored");
    pulseOvf(); pulseOvf(); pulseOvf(); expectCnt(7, "R7 ovf steps");
    wrCtrl(8'h00);

    // R8: companion tick and direction
    compDir = 1'b1;
    wrCtrl(8'hB0);
    pulseTick(); pulseTick(); expectCnt(9, "R8 comp dir up");
    compDir = 1'b0;
    pulseTick(); pulseTick(); pulseTick(); expectCnt(6, "R8 comp dir down");
    pulseOvf(); waitN(1); expectCnt(6, "R8 ovf ignored");

    // R11: wrap in both directions
    compTick = 1'b1; waitN(6); compTick = 1'b0;
    expectCnt(0, "R11 reach zero");
    waitN(1); expectOvf(0, "R11 no strobe before wrap");
    pulseTick(); expectCnt(16'hFFFF, "R11 down wrap value");
    waitN(1); expectOvf(1, "R11 down wrap strobe once");
    compDir = 1'b1;
    pulseTick(); expectCnt(0, "R11 up wrap value");
    waitN(1); expectOvf(2, "R11 up wrap strobe once");
    wrCtrl(8'h00);

    // R9/R10: quadrature, A = clock pin, B = direction pin
    extClkPin = 1'b0; waitN(5); expectCnt(0, "R4 pins ignored when off");
    wrCtrl(8'hF8);
    extDirPin = 1'b1; waitN(5); expectCnt(1, "R9 00->01 up");
    extClkPin = 1'b1; waitN(5); expectCnt(2, "R9 01->11 up");
    extDirPin = 1'b0; waitN(5); expectCnt(3, "R9 11->10 up");
    extClkPin = 1'b0; waitN(5); expectCnt(4, "R9 10->00 up");
    extClkPin = 1'b1; waitN(5); expectCnt(3, "R9 00->10 down");
    extClkPin = 1'b0; extDirPin = 1'b1; waitN(5); expectCnt(3, "R10 double change ignored");
    extDirPin = 1'b0; waitN(5); expectCnt(2, "R9 01->00 down");
    expectOvf(2, "R11 no stray strobe");

    finished = 1;
    summary();
  end
endmodule